// File: doc/BRIEF.md
# Multi-mode output compare channel

This channel drives one output pin from comparisons against a free-running timer count. A control word chooses which of two external timers is watched and which of eight behaviours applies. The behaviours are: off, one-time set, one-time clear, toggle on every match, a single pulse, a pulse train, and edge-aligned PWM with or without a fault shutdown input. A small register port holds the control word, a main compare value and a secondary compare value. In PWM the secondary value is the duty, and it is double-buffered so that it only takes effect at a period boundary. A one-cycle interrupt pulse marks each compare event, each PWM period start and each fault.

The core is a state machine with seven states. OFF is the disabled state. ARMED waits for a match with the main value in the single-match modes. RISE waits for the main match in the dual-match modes, and FALL waits for the secondary match. DONE is the terminal state of the set, clear and single-pulse modes. PWM runs the periodic output, and FAULT is where the output is shut down. Any write to the control word restarts the machine, and the new mode picks the entry state: off goes to OFF, set/clear/toggle go to ARMED, pulse/train go to RISE, and the two PWM modes go to PWM. The transitions are:
- ARMED to DONE on a match in set or clear mode; toggle mode stays in ARMED.
- RISE to FALL on a main match.
- FALL to DONE on a secondary match in single-pulse mode, or back to RISE in pulse-train mode.
- PWM to FAULT when the fault input goes low in the fault-protected mode.

A sleep input, and idle under the conditions given below, freeze the machine. Fault disconnection acts without the clock.

Top module: `ocmp_channel`

## Requirements
- R1: After reset the control word, main and secondary registers read 0x0000, and the pin, output enable and interrupt are all low.
- R2: Register address 0 is the control word, address 1 the main compare value and address 2 the secondary value; address 3 reads 0. In the control word, bit 13 is idle-stop, bit 4 is the fault flag (read-only), bit 3 is the timer select and bits 2:0 are the mode. All other bits read 0.
- R3: Mode 000 keeps the pin low, the output enable low and the interrupt low, even when the timer matches.
- R4: Mode 001 starts the pin low and drives it high at the first main match. Mode 010 starts it high and drives it low at the first match. Both then hold the pin, and only that first match pulses the interrupt.
- R5: Mode 011 starts low and inverts the pin on every main match, with an interrupt pulse on each match.
- R6: Mode 100 raises the pin at a main match and lowers it at the next secondary match. After that, further matches do nothing until the control word is written again.
- R7: Mode 101 repeats the main-rise and secondary-fall cycle indefinitely, with an interrupt pulse on each edge.
- R8: In the PWM modes (110 and 111), a rollover of the selected timer copies the secondary value into the duty register, drives the pin high (or low when the new duty is 0) and pulses the interrupt. The pin falls when the count equals the duty. A secondary write between rollovers does not change the current period.
- R9: Mode 110 ignores the fault input.
- R10: In mode 111, a low fault input immediately clears the output enable. Once the clock runs, it also sets the fault flag, drops the pin and pulses the interrupt. The flag clears only on reset, and while mode 111 is selected with the flag set, the output stays disabled.
- R11: Timer select 0 compares against timer A and 1 against timer B; the other timer has no effect.
- R12: While sleep is high the state, the pin and the fault flag hold and no interrupt is raised. A low fault input in mode 111 still clears the output enable.
- R13: In idle with idle-stop set, the channel freezes as in sleep. With idle-stop clear, it runs only while the selected timer's idle-run input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep state: channel frozen |
| idle_i | input | 1 | Idle state |
| tmr_a_cnt_i | input | 16 | Timer A count |
| tmr_a_roll_i | input | 1 | Timer A period rollover pulse |
| tmr_a_irun_i | input | 1 | Timer A keeps counting in idle |
| tmr_b_cnt_i | input | 16 | Timer B count |
| tmr_b_roll_i | input | 1 | Timer B period rollover pulse |
| tmr_b_irun_i | input | 1 | Timer B keeps counting in idle |
| flt_n_i | input | 1 | Fault input, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| pin_o | output | 1 | Output pin level |
| pin_oe_o | output | 1 | Output pin enable |
| irq_o | output | 1 | One-cycle event interrupt |

## Verification
The assertions assume two things about the inputs. First, a rollover pulse lasts one cycle per period. Second, no register write arrives while sleep is high, because the register path stays live when the machine is frozen. The stimulus follows both rules. Each timer count is held at its value for exactly one edge and then parked at 0xFFFF, a value no compare register ever holds. This way a single match cannot fire twice during the register writes that follow it. Power-state and fault inputs change only on falling edges, between the writes and timer steps.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
    localparam int CTRL_W        = 16;
    localparam int IDLE_STOP_BIT = 13;
    localparam int FLAG_BIT      = 4;
    localparam int TSEL_BIT      = 3;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_MAIN = 2'd1;
    localparam logic [1:0] A_SEC  = 2'd2;

    typedef enum logic [2:0] {
        MD_OFF   = 3'b000,
        MD_SET   = 3'b001,
        MD_CLR   = 3'b010,
        MD_TGL   = 3'b011,
        MD_ONE   = 3'b100,
        MD_TRAIN = 3'b101,
        MD_PWM   = 3'b110,
        MD_PWMF  = 3'b111
    } oc_mode_e;

    typedef enum logic [2:0] {
        S_OFF, S_ARMED, S_RISE, S_FALL, S_DONE, S_PWM, S_FAULT
    } oc_state_e;
endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              flag,
    output logic              idle_stop,
    output logic              tsel,
    output oc_mode_e          mode,
    output logic [CNT_W-1:0]  main_q,
    output logic [CNT_W-1:0]  sec_q,
    output logic [CTRL_W-1:0] rdata,
    output logic              restart
);
    assign restart = wr_en && (addr == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_stop <= 1'b0;
            tsel      <= 1'b0;
            mode      <= MD_OFF;
            main_q    <= '0;
            sec_q     <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL: begin
                    idle_stop <= wdata[IDLE_STOP_BIT];
                    tsel      <= wdata[TSEL_BIT];
                    mode      <= oc_mode_e'(wdata[2:0]);
                end
                A_MAIN:  main_q <= wdata[CNT_W-1:0];
                A_SEC:   sec_q  <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[IDLE_STOP_BIT] = idle_stop;
                rdata[FLAG_BIT]      = flag;
                rdata[TSEL_BIT]      = tsel;
                rdata[2:0]           = mode;
            end
            A_MAIN:  rdata = CTRL_W'(main_q);
            A_SEC:   rdata = CTRL_W'(sec_q);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ocmp_tsel.sv
module ocmp_tsel #(
    parameter int CNT_W = 16
) (
    input  logic             tsel,
    input  logic             idle_stop,
    input  logic             sleep,
    input  logic             idle,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic             roll_a,
    input  logic             irun_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             roll_b,
    input  logic             irun_b,
    output logic [CNT_W-1:0] cnt,
    output logic             roll,
    output logic             run
);
    logic irun_sel;

    assign cnt      = tsel ? cnt_b  : cnt_a;
    assign roll     = tsel ? roll_b : roll_a;
    assign irun_sel = tsel ? irun_b : irun_a;
    assign run      = !sleep && !(idle && (idle_stop || !irun_sel));
endmodule

// File: rtl/ocmp_fsm.sv
module ocmp_fsm
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  oc_mode_e         new_mode,
    input  oc_mode_e         mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             roll,
    input  logic [CNT_W-1:0] main_v,
    input  logic [CNT_W-1:0] sec_v,
    input  logic             flt_n,
    output logic             pin,
    output logic             irq,
    output logic             flag
);
    oc_state_e        st_q, st_d;
    logic             pin_d, irq_d, flag_d;
    logic [CNT_W-1:0] duty_q, duty_d;
    logic             hit_main, hit_sec, hit_duty;

    assign hit_main = (cnt == main_v);
    assign hit_sec  = (cnt == sec_v);
    assign hit_duty = (cnt == duty_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_OFF;
            pin    <= 1'b0;
            irq    <= 1'b0;
            flag   <= 1'b0;
            duty_q <= '0;
        end else begin
            st_q   <= st_d;
            pin    <= pin_d;
            irq    <= irq_d;
            flag   <= flag_d;
            duty_q <= duty_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        pin_d  = pin;
        irq_d  = 1'b0;
        flag_d = flag;
        duty_d = duty_q;
        if (restart) begin
            duty_d = '0;
            unique case (new_mode)
                MD_OFF:                    begin st_d = S_OFF;   pin_d = 1'b0; end
                MD_SET, MD_TGL:            begin st_d = S_ARMED; pin_d = 1'b0; end
                MD_CLR:                    begin st_d = S_ARMED; pin_d = 1'b1; end
                MD_ONE, MD_TRAIN:          begin st_d = S_RISE;  pin_d = 1'b0; end
                MD_PWM, MD_PWMF:           begin st_d = S_PWM;   pin_d = 1'b0; end
            endcase
        end else if (run) begin
            unique case (st_q)
                S_OFF, S_DONE, S_FAULT: ;
                S_ARMED: if (hit_main) begin
                    irq_d = 1'b1;
                    if (mode == MD_SET) begin
                        pin_d = 1'b1;
                        st_d  = S_DONE;
                    end else if (mode == MD_CLR) begin
                        pin_d = 1'b0;
                        st_d  = S_DONE;
                    end else begin
                        pin_d = !pin;
                    end
                end
                S_RISE: if (hit_main) begin
                    pin_d = 1'b1;
                    irq_d = 1'b1;
                    st_d  = S_FALL;
                end
                S_FALL: if (hit_sec) begin
                    pin_d = 1'b0;
                    irq_d = 1'b1;
                    st_d  = (mode == MD_TRAIN) ? S_RISE : S_DONE;
                end
                S_PWM: begin
                    if (mode == MD_PWMF && !flt_n) begin
                        st_d   = S_FAULT;
                        pin_d  = 1'b0;
                        flag_d = 1'b1;
                        irq_d  = 1'b1;
                    end else if (roll) begin
                        duty_d = sec_v;
                        pin_d  = (sec_v != '0);
                        irq_d  = 1'b1;
                    end else if (hit_duty) begin
                        pin_d = 1'b0;
                    end
                end
                default: st_d = S_OFF;
            endcase
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag); // R10
    AST_FAULT_STATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FAULT) |-> flag); // R10
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> ($stable(pin) && $stable(st_q) && !irq)); // R12
    AST_DUTY_AT_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(run && roll)) |=> $stable(duty_q)); // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DONE && !restart) |=> ($stable(pin) && !irq)); // R4
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              idle_i,
    input  logic [CNT_W-1:0]  tmr_a_cnt_i,
    input  logic              tmr_a_roll_i,
    input  logic              tmr_a_irun_i,
    input  logic [CNT_W-1:0]  tmr_b_cnt_i,
    input  logic              tmr_b_roll_i,
    input  logic              tmr_b_irun_i,
    input  logic              flt_n_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [CTRL_W-1:0] reg_wdata_i,
    output logic [CTRL_W-1:0] reg_rdata_o,
    output logic              pin_o,
    output logic              pin_oe_o,
    output logic              irq_o
);
    logic             idle_stop, tsel, restart, run, roll, flag;
    oc_mode_e         mode;
    logic [CNT_W-1:0] main_q, sec_q, cnt;

    ocmp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_i), .addr(reg_addr_i),
        .wdata(reg_wdata_i), .flag(flag), .idle_stop(idle_stop), .tsel(tsel),
        .mode(mode), .main_q(main_q), .sec_q(sec_q), .rdata(reg_rdata_o),
        .restart(restart)
    );

    ocmp_tsel #(.CNT_W(CNT_W)) u_tsel (
        .tsel(tsel), .idle_stop(idle_stop), .sleep(sleep_i), .idle(idle_i),
        .cnt_a(tmr_a_cnt_i), .roll_a(tmr_a_roll_i), .irun_a(tmr_a_irun_i),
        .cnt_b(tmr_b_cnt_i), .roll_b(tmr_b_roll_i), .irun_b(tmr_b_irun_i),
        .cnt(cnt), .roll(roll), .run(run)
    );

    ocmp_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .new_mode(oc_mode_e'(reg_wdata_i[2:0])), .mode(mode), .cnt(cnt),
        .roll(roll), .main_v(main_q), .sec_v(sec_q), .flt_n(flt_n_i),
        .pin(pin_o), .irq(irq_o), .flag(flag)
    );

    assign pin_oe_o = (mode != MD_OFF) &&
                      !(mode == MD_PWMF && (!flt_n_i || flag));

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF) |-> (!pin_o && !irq_o)); // R3
endmodule

// File: tb/tb_ocmp_channel.sv
module tb_ocmp_channel;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PARK = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0, idle_i = 1'b0;
    logic [15:0] cnt_a = PARK, cnt_b = PARK;
    logic        roll_a = 1'b0, roll_b = 1'b0;
    logic        irun_a = 1'b0, irun_b = 1'b0;
    logic        flt_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pin, pin_oe, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocmp_channel dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .idle_i(idle_i),
        .tmr_a_cnt_i(cnt_a), .tmr_a_roll_i(roll_a), .tmr_a_irun_i(irun_a),
        .tmr_b_cnt_i(cnt_b), .tmr_b_roll_i(roll_b), .tmr_b_irun_i(irun_b),
        .flt_n_i(flt_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pin_o(pin),
        .pin_oe_o(pin_oe), .irq_o(irq)
    );

    // pulse train vectors, main=5 secondary=8: {count, expected pin, expected irq}
    localparam logic [17:0] TRAIN_VEC [0:7] = '{
        {16'd4, 1'b0, 1'b0}, {16'd5, 1'b1, 1'b1}, {16'd6, 1'b1, 1'b0},
        {16'd8, 1'b0, 1'b1}, {16'd9, 1'b0, 1'b0}, {16'd5, 1'b1, 1'b1},
        {16'd8, 1'b0, 1'b1}, {16'd5, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic tick(input logic [15:0] a, input logic ra, input logic [15:0] b, input logic rb);
        cnt_a = a; roll_a = ra; cnt_b = b; roll_b = rb;
        @(negedge clk);
        cnt_a = PARK; roll_a = 1'b0; cnt_b = PARK; roll_b = 1'b0;
    endtask

    task automatic ta(input logic [15:0] a, input logic ra);
        tick(a, ra, PARK, 1'b0);
    endtask

    task automatic po(input string tag, input logic ep, input logic ei);
        chk({tag, " pin"}, 16'(pin), 16'(ep));
        chk({tag, " irq"}, 16'(irq), 16'(ei));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 ctrl", 2'd0, 16'h0000);
        rd("R1 main", 2'd1, 16'h0000);
        rd("R1 sec", 2'd2, 16'h0000);
        po("R1", 1'b0, 1'b0);
        chk("R1 oe", 16'(pin_oe), 16'h0);

        // R2 register map
        wr(2'd0, 16'hFFFF);
        rd("R2 ctrl mask", 2'd0, 16'h200F);
        wr(2'd1, 16'h1234);
        rd("R2 main", 2'd1, 16'h1234);
        wr(2'd2, 16'hBEEF);
        rd("R2 sec", 2'd2, 16'hBEEF);
        rd("R2 addr3", 2'd3, 16'h0000);

        // R3 disabled
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd5);
        ta(16'd5, 1'b1);
        po("R3", 1'b0, 1'b0);
        chk("R3 oe", 16'(pin_oe), 16'h0);

        // R4 set and clear
        wr(2'd1, 16'd10);
        wr(2'd0, 16'h0001);
        po("R4 set start", 1'b0, 1'b0);
        chk("R4 oe", 16'(pin_oe), 16'h1);
        ta(16'd10, 1'b0); po("R4 set match", 1'b1, 1'b1);
        ta(16'd10, 1'b0); po("R4 set hold", 1'b1, 1'b0);
        wr(2'd0, 16'h0002);
        po("R4 clr start", 1'b1, 1'b0);
        ta(16'd10, 1'b0); po("R4 clr match", 1'b0, 1'b1);
        ta(16'd10, 1'b0); po("R4 clr hold", 1'b0, 1'b0);

        // R5 toggle
        wr(2'd0, 16'h0003);
        ta(16'd10, 1'b0); po("R5 t1", 1'b1, 1'b1);
        ta(16'd9, 1'b0);  po("R5 miss", 1'b1, 1'b0);
        ta(16'd10, 1'b0); po("R5 t2", 1'b0, 1'b1);

        // R6 single pulse
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd8);
        wr(2'd0, 16'h0004);
        ta(16'd8, 1'b0); po("R6 early sec", 1'b0, 1'b0);
        ta(16'd5, 1'b0); po("R6 rise", 1'b1, 1'b1);
        ta(16'd8, 1'b0); po("R6 fall", 1'b0, 1'b1);
        ta(16'd5, 1'b0); po("R6 after", 1'b0, 1'b0);

        // R7 pulse train (table)
        wr(2'd0, 16'h0005);
        for (int i = 0; i < 8; i++) begin
            ta(TRAIN_VEC[i][17:2], 1'b0);
            po($sformatf("R7 vec%0d", i), TRAIN_VEC[i][1], TRAIN_VEC[i][0]);
        end

        // R8 PWM duty buffering
        wr(2'd2, 16'd3);
        wr(2'd0, 16'h0006);
        ta(16'd0, 1'b1); po("R8 roll", 1'b1, 1'b1);
        wr(2'd2, 16'd6);
        ta(16'd3, 1'b0); po("R8 old duty", 1'b0, 1'b0);
        ta(16'd0, 1'b1); po("R8 roll2", 1'b1, 1'b1);
        ta(16'd3, 1'b0); po("R8 new duty keep", 1'b1, 1'b0);
        ta(16'd6, 1'b0); po("R8 new duty fall", 1'b0, 1'b0);
        wr(2'd2, 16'd0);
        ta(16'd0, 1'b1); po("R8 zero duty", 1'b0, 1'b1);

        // R9 fault ignored in mode 110
        wr(2'd2, 16'd3);
        flt_n = 1'b0;
        ta(16'd0, 1'b1); po("R9 roll", 1'b1, 1'b1);
        chk("R9 oe", 16'(pin_oe), 16'h1);
        ta(16'd3, 1'b0); po("R9 fall", 1'b0, 1'b0);
        rd("R9 flag", 2'd0, 16'h0006);
        flt_n = 1'b1;

        // R12 sleep with fault; R10 fault protection
        wr(2'd0, 16'h0007);
        ta(16'd0, 1'b1); po("R10 roll", 1'b1, 1'b1);
        sleep_i = 1'b1;
        flt_n = 1'b0;
        #1;
        chk("R12 oe fault in sleep", 16'(pin_oe), 16'h0);
        @(negedge clk);
        po("R12 sleep hold", 1'b1, 1'b0);
        rd("R12 no flag in sleep", 2'd0, 16'h0007);
        sleep_i = 1'b0;
        @(negedge clk);
        po("R10 fault", 1'b0, 1'b1);
        rd("R10 flag set", 2'd0, 16'h0017);
        chk("R10 oe", 16'(pin_oe), 16'h0);
        flt_n = 1'b1;
        #1;
        chk("R10 oe latched", 16'(pin_oe), 16'h0);
        wr(2'd0, 16'h0007);
        rd("R10 sw no clear", 2'd0, 16'h0017);
        chk("R10 oe after rewrite", 16'(pin_oe), 16'h0);
        wr(2'd0, 16'h0001);
        rd("R10 flag sticky", 2'd0, 16'h0011);
        chk("R10 oe other mode", 16'(pin_oe), 16'h1);

        // R11 timer select
        wr(2'd1, 16'd7);
        wr(2'd0, 16'h0009);
        tick(16'd7, 1'b0, 16'd2, 1'b0); po("R11 timer A ignored", 1'b0, 1'b0);
        tick(16'd2, 1'b0, 16'd7, 1'b0); po("R11 timer B match", 1'b1, 1'b1);

        // R12 sleep freezes toggle
        wr(2'd1, 16'd4);
        wr(2'd0, 16'h0003);
        ta(16'd4, 1'b0); po("R12 run", 1'b1, 1'b1);
        sleep_i = 1'b1;
        ta(16'd4, 1'b0); po("R12 frozen", 1'b1, 1'b0);
        sleep_i = 1'b0;
        ta(16'd4, 1'b0); po("R12 resume", 1'b0, 1'b1);

        // R13 idle gating
        wr(2'd0, 16'h2003);
        idle_i = 1'b1;
        irun_a = 1'b1;
        ta(16'd4, 1'b0); po("R13 idle stop", 1'b0, 1'b0);
        wr(2'd0, 16'h0003);
        irun_a = 1'b0;
        ta(16'd4, 1'b0); po("R13 timer halted", 1'b0, 1'b0);
        irun_a = 1'b1;
        ta(16'd4, 1'b0); po("R13 timer runs", 1'b1, 1'b1);
        idle_i = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule